// File: doc/BRIEF.md
# Serial Command Register Port

This block lets a host configure a small bank of 8-bit control registers over a four-wire serial link. The link has an active-low select, a serial clock, a serial input and a serial output. The block oversamples the link with its own faster system clock, so all of its logic runs in one clock domain. Every transfer is a run of bytes, most significant bit first, inside one select-low period. The first byte of that period is a command code. It picks one of four operations: a burst write that increments the address, a read that returns data one byte after each address, a two-period read-all that streams data, or a soft reset of the register bank.

Registers 0x00 to 0x0B hold settings and appear in parallel on a flat output bus. Address 0x0C is a read-only view of an external status byte. A lock bit in register 0x00 can turn the serial port off while the device enable input is low. This keeps a standby device from being reprogrammed until it is enabled again.

Top module: `sreg_port`

## Requirements
- R1: After the synchronous reset, registers 0x02 and 0x04 hold 0x3B, all other stored registers hold 0x00, and both `sdo` and `soft_rst` are low.
- R2: SDI is captured on SCLK rising edges, most significant bit first, and `sdo` only changes after SCLK falling edges. Raising `cs_n` throws away any partial byte, and the next select-low period starts again with a command byte.
- R3: Command 0x01 is followed by a start address. Each later byte is written to the current address, and the address then increments by one.
- R4: Register 0x00 keeps only bits 3:0 and register 0x01 keeps only bits 5:0. The other bits of these two registers are reserved and always read as 0. All other stored registers keep all 8 bits.
- R5: A write to address 0x0C or to any address from 0x0D to 0xFF changes no register.
- R6: With command 0x02, each later byte is a read address. `sdo` returns 0x00 during the address byte that follows the command. During every later byte it returns the data for the address sent one byte earlier. Unmapped addresses read 0x00.
- R7: A read of address 0x0C returns the current value of `status_in`.
- R8: Command 0x03 followed by an address arms a read-all. In the next select-low period, `sdo` streams the data of that address and then of each next address, with no command byte needed.
- R9: An armed read-all address serves only the next select-low period. The period after that decodes a command again.
- R10: Command 0x04 returns every stored register to its reset value and drives `soft_rst` high for exactly one system clock.
- R11: When bit 0 of register 0x00 is 1 and `dev_en` is low, select-low periods are ignored: no writes happen and `sdo` stays 0. If the lock bit is set by a write in the middle of a period, the rest of that period is ignored.
- R12: An undefined command code causes the rest of its select-low period to be ignored, and `sdo` stays 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial link |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock, idles low |
| sdi | input | 1 | Serial data into the block |
| dev_en | input | 1 | Device enable; low means standby |
| status_in | input | 8 | Status byte seen at read-only address 0x0C |
| sdo | output | 1 | Serial data out of the block |
| cfg_flat | output | 96 | Registers 0x00..0x0B, register n on bits 8n+7:8n |
| soft_rst | output | 1 | One-cycle pulse issued by command 0x04 |

## Verification
Two events can fall in the same cycle. One is a completed write that sets the lock bit. The other is the lock condition taking away the port's access to the frame that carried that write. The bench provokes this with `dev_en` low, sending one burst that first sets the lock bit in register 0x00 and then sends a further data byte for register 0x01. The run passes if register 0x00 shows the lock bit, register 0x01 keeps its old value, and a later read in the same standby state returns only zeros. Raising `dev_en` must then restore normal writes.

// File: rtl/sreg_pkg.sv
// Package: shared constants, decoder state type and the per-register
// write-mask and reset-value tables of the serial register port.
// Assumes 8-bit registers; stored registers are indexed from 0.
package sreg_pkg;

    localparam int DATA_W   = 8;
    localparam int ADDR_W   = 8;
    localparam int NUM_RW   = 12;
    localparam int RO_ADDR  = 12;
    localparam int LOCK_BIT = 0;

    localparam logic [DATA_W-1:0] OP_WRITE = 8'h01;
    localparam logic [DATA_W-1:0] OP_READ  = 8'h02;
    localparam logic [DATA_W-1:0] OP_RDALL = 8'h03;
    localparam logic [DATA_W-1:0] OP_RESET = 8'h04;

    typedef enum logic [2:0] {
        ST_CMD,
        ST_WADDR,
        ST_WDATA,
        ST_RADDR,
        ST_RAADDR,
        ST_STREAM,
        ST_SKIP
    } dec_state_e;

    // Bits of a stored register that hold state; all others read as zero.
    function automatic logic [DATA_W-1:0] reg_mask(input int idx);
        case (idx)
            0:       return 8'h0F;
            1:       return 8'h3F;
            default: return 8'hFF;
        endcase
    endfunction

    // Power-up value of a stored register.
    function automatic logic [DATA_W-1:0] reg_rst(input int idx);
        case (idx)
            2, 4:    return 8'h3B;
            default: return 8'h00;
        endcase
    endfunction

    // All power-up values packed the way the flat output bus carries them.
    function automatic logic [NUM_RW*DATA_W-1:0] rst_flat();
        logic [NUM_RW*DATA_W-1:0] v;
        v = '0;
        for (int i = 0; i < NUM_RW; i++) begin
            v[i*DATA_W +: DATA_W] = reg_rst(i);
        end
        return v;
    endfunction

endpackage

// File: rtl/sreg_sync.sv
// Module: multi-bit two-or-more stage synchronizer for slow asynchronous
// inputs. Assumes each bit is sampled independently; RST_VAL is the idle level.
module sreg_sync #(
    parameter int           W       = 1,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);

    logic [STAGES-1:0][W-1:0] pipe;

    // Shift the asynchronous value through the flop chain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pipe <= {STAGES{RST_VAL}};
        end else begin
            pipe <= {pipe[STAGES-2:0], async_in};
        end
    end

    assign sync_out = pipe[STAGES-1];

endmodule

// File: rtl/sreg_shift.sv
// Module: byte engine. Detects serial clock edges, assembles received
// bytes MSB first on rising edges and drives the output bit after falling
// edges. Assumes the serial clock idles low and is much slower than clk.
module sreg_shift #(
    parameter int DW = sreg_pkg::DATA_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          sclk_s,
    input  logic          sdi_s,
    input  logic          prime,
    input  logic [DW-1:0] tx_byte,
    output logic          rx_valid,
    output logic [DW-1:0] rx_byte,
    output logic          sdo
);

    localparam int CW = $clog2(DW);

    logic          sclk_q;
    logic [CW-1:0] bit_cnt;
    logic [DW-1:0] rx_sh;
    logic [DW-1:0] tx_sh;
    logic          rise;
    logic          fall;

    // Remember the previous serial clock level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sclk_q <= 1'b0;
        else        sclk_q <= sclk_s;
    end

    assign rise = sclk_s & ~sclk_q;
    assign fall = ~sclk_s & sclk_q;

    // Receive on rising edges, transmit after falling edges, clear when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_cnt  <= '0;
            rx_sh    <= '0;
            tx_sh    <= '0;
            sdo      <= 1'b0;
            rx_valid <= 1'b0;
            rx_byte  <= '0;
        end else begin
            rx_valid <= 1'b0;
            if (!active) begin
                bit_cnt <= '0;
                tx_sh   <= '0;
                sdo     <= 1'b0;
            end else if (prime) begin
                sdo   <= tx_byte[DW-1];
                tx_sh <= {tx_byte[DW-2:0], 1'b0};
            end else if (rise) begin
                rx_sh <= {rx_sh[DW-2:0], sdi_s};
                if (bit_cnt == CW'(DW-1)) begin
                    bit_cnt  <= '0;
                    rx_valid <= 1'b1;
                    rx_byte  <= {rx_sh[DW-2:0], sdi_s};
                end else begin
                    bit_cnt <= bit_cnt + 1'b1;
                end
            end else if (fall) begin
                if (bit_cnt == '0) begin
                    sdo   <= tx_byte[DW-1];
                    tx_sh <= {tx_byte[DW-2:0], 1'b0};
                end else begin
                    sdo   <= tx_sh[DW-1];
                    tx_sh <= {tx_sh[DW-2:0], 1'b0};
                end
            end
        end
    end

    // R2
    idle_sdo_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> !sdo);

    // R2
    byte_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |-> $past(rise));

endmodule

// File: rtl/sreg_decode.sv
// Module: command decoder. Interprets the first byte of each select-low
// period, tracks the auto-increment pointer, arms and runs read-all, issues
// write strobes and the soft reset pulse, and chooses the next output byte.
// Assumes rd_data is a combinational function of rd_addr.
module sreg_decode
    import sreg_pkg::*;
#(
    parameter int DW = DATA_W,
    parameter int AW = ADDR_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          rx_valid,
    input  logic [DW-1:0] rx_byte,
    input  logic [DW-1:0] rd_data,
    output logic [AW-1:0] rd_addr,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [DW-1:0] wr_data,
    output logic [DW-1:0] tx_byte,
    output logic          prime,
    output logic          soft_rst
);

    dec_state_e    state;
    logic [AW-1:0] ptr;
    logic [AW-1:0] ra_addr;
    logic          ra_pend;
    logic          act_q;
    logic          frame_start;

    assign frame_start = active & ~act_q;

    // Select which address the register bank is asked to read this cycle.
    always_comb begin
        if (frame_start)           rd_addr = ra_addr;
        else if (state == ST_RADDR) rd_addr = rx_byte;
        else                        rd_addr = ptr;
    end

    // Frame start handling and per-byte command sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_CMD;
            ptr      <= '0;
            ra_addr  <= '0;
            ra_pend  <= 1'b0;
            act_q    <= 1'b0;
            tx_byte  <= '0;
            prime    <= 1'b0;
            wr_en    <= 1'b0;
            wr_addr  <= '0;
            wr_data  <= '0;
            soft_rst <= 1'b0;
        end else begin
            act_q    <= active;
            prime    <= 1'b0;
            wr_en    <= 1'b0;
            soft_rst <= 1'b0;
            if (!active) begin
                state <= ST_CMD;
            end else if (frame_start) begin
                prime <= 1'b1;
                if (ra_pend) begin
                    state   <= ST_STREAM;
                    tx_byte <= rd_data;
                    ptr     <= ra_addr + AW'(1);
                    ra_pend <= 1'b0;
                end else begin
                    state   <= ST_CMD;
                    tx_byte <= '0;
                end
            end else if (rx_valid) begin
                case (state)
                    ST_CMD: begin
                        tx_byte <= '0;
                        case (rx_byte)
                            OP_WRITE: state <= ST_WADDR;
                            OP_READ:  state <= ST_RADDR;
                            OP_RDALL: state <= ST_RAADDR;
                            OP_RESET: begin
                                soft_rst <= 1'b1;
                                state    <= ST_SKIP;
                            end
                            default:  state <= ST_SKIP;
                        endcase
                    end
                    ST_WADDR: begin
                        ptr   <= rx_byte;
                        state <= ST_WDATA;
                    end
                    ST_WDATA: begin
                        wr_en   <= 1'b1;
                        wr_addr <= ptr;
                        wr_data <= rx_byte;
                        ptr     <= ptr + AW'(1);
                    end
                    ST_RADDR: begin
                        tx_byte <= rd_data;
                    end
                    ST_RAADDR: begin
                        ra_addr <= rx_byte;
                        ra_pend <= 1'b1;
                        state   <= ST_SKIP;
                    end
                    ST_STREAM: begin
                        tx_byte <= rd_data;
                        ptr     <= ptr + AW'(1);
                    end
                    default: begin
                        tx_byte <= '0;
                    end
                endcase
            end
        end
    end

    // R10
    rst_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> !soft_rst);

    // R9
    ra_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && ra_pend) |=> !ra_pend);

    // R11
    write_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> $past(active));

endmodule

// File: rtl/sreg_bank.sv
// Module: register bank. Stores the writable registers with per-register
// masks, returns read data for any 8-bit address, and restores power-up
// values on reset or soft reset. Assumes one write per cycle at most.
module sreg_bank
    import sreg_pkg::*;
#(
    parameter int DW  = DATA_W,
    parameter int AW  = ADDR_W,
    parameter int NRW = NUM_RW,
    parameter int ROA = RO_ADDR
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              soft_rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DW-1:0]     wr_data,
    input  logic [AW-1:0]     rd_addr,
    input  logic [DW-1:0]     status_in,
    output logic [DW-1:0]     rd_data,
    output logic [NRW*DW-1:0] regs_flat
);

    logic [DW-1:0] q [NRW];

    for (genvar i = 0; i < NRW; i++) begin : g_reg
        // Hold one register: reset value, or masked write data when addressed.
        always_ff @(posedge clk) begin
            if (!rst_n || soft_rst) begin
                q[i] <= reg_rst(i);
            end else if (wr_en && wr_addr == AW'(i)) begin
                q[i] <= wr_data & reg_mask(i);
            end
        end
        assign regs_flat[i*DW +: DW] = q[i];
    end

    // Read mux: stored registers, then the status view, else zero.
    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NRW; i++) begin
            if (rd_addr == AW'(i)) rd_data = q[i];
        end
        if (rd_addr == AW'(ROA)) rd_data = status_in;
    end

    // R10
    soft_reset_values_chk: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (regs_flat == rst_flat()));

    // R5
    ignore_unmapped_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr >= AW'(NRW) && !soft_rst) |=> $stable(regs_flat));

endmodule

// File: rtl/sreg_port.sv
// Module: top of the serial command register port. Synchronizes the link
// pins, applies the standby lock and wires the byte engine, the command
// decoder and the register bank. Assumes SCLK is at least 8x slower than clk.
module sreg_port
    import sreg_pkg::*;
#(
    parameter int DW  = DATA_W,
    parameter int AW  = ADDR_W,
    parameter int NRW = NUM_RW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              dev_en,
    input  logic [DW-1:0]     status_in,
    output logic              sdo,
    output logic [NRW*DW-1:0] cfg_flat,
    output logic              soft_rst
);

    logic          cs_s;
    logic          sclk_s;
    logic          sdi_s;
    logic          locked;
    logic          active;
    logic          rx_valid;
    logic [DW-1:0] rx_byte;
    logic [DW-1:0] tx_byte;
    logic          prime;
    logic [AW-1:0] rd_addr;
    logic [DW-1:0] rd_data;
    logic          wr_en;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;

    sreg_sync #(.W(3), .STAGES(2), .RST_VAL(3'b100)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in ({cs_n, sclk, sdi}),
        .sync_out ({cs_s, sclk_s, sdi_s})
    );

    assign locked = cfg_flat[LOCK_BIT] & ~dev_en;
    assign active = ~cs_s & ~locked;

    sreg_shift #(.DW(DW)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .sclk_s   (sclk_s),
        .sdi_s    (sdi_s),
        .prime    (prime),
        .tx_byte  (tx_byte),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .sdo      (sdo)
    );

    sreg_decode #(.DW(DW), .AW(AW)) u_decode (
        .clk      (clk),
        .rst_n    (rst_n),
        .active   (active),
        .rx_valid (rx_valid),
        .rx_byte  (rx_byte),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .tx_byte  (tx_byte),
        .prime    (prime),
        .soft_rst (soft_rst)
    );

    sreg_bank #(.DW(DW), .AW(AW), .NRW(NRW), .ROA(RO_ADDR)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .soft_rst  (soft_rst),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .status_in (status_in),
        .rd_data   (rd_data),
        .regs_flat (cfg_flat)
    );

    // R11
    locked_no_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked |-> !wr_en);

endmodule

// File: tb/sreg_port_tb.sv
// Bench: directed corner cases followed by seeded random bursts, all
// checked against a register model kept in the bench.
module sreg_port_tb;

    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic        dev_en = 1'b1;
    logic [7:0]  status_in = 8'hC3;
    logic        sdo;
    logic [95:0] cfg_flat;
    logic        soft_rst;

    int checks = 0;
    int failures = 0;
    int rst_hi = 0;
    bit done = 0;

    logic [7:0] txb [8];
    logic [7:0] rxb [8];
    logic [7:0] mdl [12];

    sreg_port u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cs_n      (cs_n),
        .sclk      (sclk),
        .sdi       (sdi),
        .dev_en    (dev_en),
        .status_in (status_in),
        .sdo       (sdo),
        .cfg_flat  (cfg_flat),
        .soft_rst  (soft_rst)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) if (soft_rst) rst_hi++;

    function automatic logic [7:0] mask_of(int a);
        if (a == 0) return 8'h0F;
        if (a == 1) return 8'h3F;
        return 8'hFF;
    endfunction

    function automatic logic [7:0] rst_of(int a);
        return (a == 2 || a == 4) ? 8'h3B : 8'h00;
    endfunction

    function automatic logic [7:0] exp_read(int a);
        if (a < 12) return mdl[a];
        if (a == 12) return status_in;
        return 8'h00;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 12; i++) mdl[i] = rst_of(i);
    endtask

    task automatic wait_clk(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic chk_regs(string tag);
        for (int i = 0; i < 12; i++) chk(tag, {24'd0, cfg_flat[i*8 +: 8]}, {24'd0, mdl[i]});
    endtask

    // One select-low period carrying n bytes from txb; sdo captured into rxb.
    task automatic frame(int n);
        cs_n = 1'b0;
        wait_clk(HALF);
        for (int k = 0; k < n; k++) begin
            for (int b = 7; b >= 0; b--) begin
                sdi = txb[k][b];
                wait_clk(HALF);
                rxb[k][b] = sdo;
                sclk = 1'b1;
                wait_clk(HALF);
                sclk = 1'b0;
            end
        end
        wait_clk(HALF);
        cs_n = 1'b1;
        sdi = 1'b0;
        wait_clk(2*HALF);
    endtask

    task automatic partial(int nbits);
        cs_n = 1'b0;
        wait_clk(HALF);
        for (int b = 0; b < nbits; b++) begin
            sdi = b[0];
            wait_clk(HALF);
            sclk = 1'b1;
            wait_clk(HALF);
            sclk = 1'b0;
        end
        wait_clk(HALF);
        cs_n = 1'b1;
        sdi = 1'b0;
        wait_clk(2*HALF);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog: run hung actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        int unsigned seed;
        int          hits;
        seed = $urandom(32'd20240611);
        model_reset();
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(4);

        // R1 reset state
        chk_regs("R1 reset value");
        chk("R1 sdo idle", {31'd0, sdo}, 32'd0);
        chk("R1 soft_rst idle", {31'd0, soft_rst}, 32'd0);

        // R3 burst write, R4 reserved bits in 0x00 and 0x01
        txb[0] = 8'h01; txb[1] = 8'h00; txb[2] = 8'hF2; txb[3] = 8'hFF;
        txb[4] = 8'hAA; txb[5] = 8'h55;
        frame(6);
        mdl[0] = 8'h02; mdl[1] = 8'h3F; mdl[2] = 8'hAA; mdl[3] = 8'h55;
        chk_regs("R3 R4 burst write with masks");

        // R5 writes past the last stored register are dropped
        txb[0] = 8'h01; txb[1] = 8'h0A; txb[2] = 8'h5A; txb[3] = 8'h11;
        txb[4] = 8'h22; txb[5] = 8'h33;
        frame(6);
        mdl[10] = 8'h5A; mdl[11] = 8'h11;
        chk_regs("R5 ignore 0x0C and above");

        // R6 pipelined read list, R7 status view
        txb[0] = 8'h02; txb[1] = 8'h03; txb[2] = 8'h0C; txb[3] = 8'h20;
        txb[4] = 8'h02; txb[5] = 8'h00;
        frame(6);
        chk("R6 lead byte 0", {24'd0, rxb[0]}, 32'h0);
        chk("R6 lead byte 1", {24'd0, rxb[1]}, 32'h0);
        chk("R6 data of 0x03", {24'd0, rxb[2]}, {24'd0, mdl[3]});
        chk("R7 status read", {24'd0, rxb[3]}, {24'd0, status_in});
        chk("R6 unmapped read", {24'd0, rxb[4]}, 32'h0);
        chk("R6 data of 0x02", {24'd0, rxb[5]}, {24'd0, mdl[2]});

        // R8 read-all across two select periods
        txb[0] = 8'h03; txb[1] = 8'h0A;
        frame(2);
        txb[0] = 8'hFF; txb[1] = 8'hFF; txb[2] = 8'hFF; txb[3] = 8'hFF;
        frame(4);
        for (int k = 0; k < 4; k++)
            chk("R8 read-all stream", {24'd0, rxb[k]}, {24'd0, exp_read(10 + k)});

        // R9 the following period decodes a command again
        txb[0] = 8'h02; txb[1] = 8'h02; txb[2] = 8'h00;
        frame(3);
        chk("R9 no stale stream", {24'd0, rxb[0]}, 32'h0);
        chk("R9 command decoded", {24'd0, rxb[2]}, {24'd0, mdl[2]});

        // R2 partial byte aborted by select high
        partial(5);
        txb[0] = 8'h01; txb[1] = 8'h05; txb[2] = 8'h77;
        frame(3);
        mdl[5] = 8'h77;
        chk("R2 realigned after abort", {24'd0, cfg_flat[5*8 +: 8]}, 32'h77);

        // R12 undefined command ignores the rest of the period
        txb[0] = 8'h07; txb[1] = 8'h01; txb[2] = 8'h05; txb[3] = 8'h99;
        frame(4);
        chk("R12 no write", {24'd0, cfg_flat[5*8 +: 8]}, 32'h77);
        chk("R12 sdo zero", {24'd0, rxb[1] | rxb[2] | rxb[3]}, 32'h0);

        // R11 lock set mid-frame in standby; tail byte dropped
        dev_en = 1'b0;
        txb[0] = 8'h01; txb[1] = 8'h00; txb[2] = 8'h01; txb[3] = 8'h44;
        frame(4);
        mdl[0] = 8'h01;
        chk_regs("R11 lock set, tail ignored");
        txb[0] = 8'h02; txb[1] = 8'h01; txb[2] = 8'h00;
        frame(3);
        chk("R11 locked read zero", {24'd0, rxb[2]}, 32'h0);
        txb[0] = 8'h01; txb[1] = 8'h01; txb[2] = 8'h55;
        frame(3);
        chk("R11 locked write ignored", {24'd0, cfg_flat[1*8 +: 8]}, {24'd0, mdl[1]});
        dev_en = 1'b1;
        wait_clk(2);
        frame(3);
        mdl[1] = 8'h15;
        chk("R11 unlocked write", {24'd0, cfg_flat[1*8 +: 8]}, 32'h15);
        txb[0] = 8'h01; txb[1] = 8'h00; txb[2] = 8'h00;
        frame(3);
        mdl[0] = 8'h00;

        // R10 soft reset command
        hits = rst_hi;
        txb[0] = 8'h04;
        frame(1);
        model_reset();
        chk_regs("R10 registers restored");
        chk("R10 pulse width", rst_hi - hits, 32'd1);

        // Random bursts and reads, R3 R4 R5 R6 R7 R8
        for (int it = 0; it < 20; it++) begin
            int start;
            int len;
            status_in = 8'($urandom);
            start = $urandom_range(0, 15);
            len = $urandom_range(1, 4);
            txb[0] = 8'h01; txb[1] = 8'(start);
            for (int k = 0; k < len; k++) txb[2 + k] = 8'($urandom);
            frame(len + 2);
            for (int k = 0; k < len; k++)
                if (start + k < 12) mdl[start + k] = txb[2 + k] & mask_of(start + k);
            chk_regs("R3 R4 R5 random write");

            txb[0] = 8'h02;
            for (int k = 0; k < 3; k++) txb[1 + k] = 8'($urandom_range(0, 15));
            txb[4] = 8'h00;
            frame(5);
            for (int k = 0; k < 3; k++)
                chk("R6 R7 random read", {24'd0, rxb[2 + k]}, {24'd0, exp_read(int'(txb[1 + k]))});

            if (it % 4 == 0) begin
                start = $urandom_range(8, 14);
                txb[0] = 8'h03; txb[1] = 8'(start);
                frame(2);
                txb[0] = 8'h00; txb[1] = 8'h00; txb[2] = 8'h00;
                frame(3);
                for (int k = 0; k < 3; k++)
                    chk("R8 random read-all", {24'd0, rxb[k]}, {24'd0, exp_read(start + k)});
            end
        end

        finish_run();
    end

endmodule